// File: doc/BRIEF.md
# Speech Parameter Bit-Serial Loader

This block sits between the bit-serial instruction decoder of a speech synthesiser and the parameter register file read by the filter core. The decoder tells it, one field at a time, which register to update, how wide the field is, whether the field carries its own sign bit and which update to apply. The field's bits then arrive one per clock. The register file holds seventeen entries: a repeat count, pitch, amplitude, twelve filter coefficients and two interpolation steps.

Fields can be narrower than their register. Each field is stored against the top of its register. A full load clears the bits below the field. An MSB replace keeps those bits. A delta adds the field as a two's-complement number into the top bits and leaves the low bits untouched. A zero operation needs no data bits. The filter core reads any register through a combinational read port. A one-cycle done pulse marks every completed write.

Top module: `speech_param_loader`

## Requirements
- R1: After reset every register reads 0, `busy` is 0 and `wr_done` is 0.
- R2: Data bits arrive least significant bit first. An 8-bit full load (`seg_op`=00, `seg_len_m1`=7) stores the field value unchanged.
- R3: A full load of a field narrower than its register puts the field in the top bits and clears every lower bit.
- R4: An MSB replace (`seg_op`=01) overwrites only the top field-width bits and keeps the lower bits.
- R5: A delta (`seg_op`=10) adds the field as a two's-complement value of its own width into the top bits, modulo 2^width. The carry out is dropped and the lower bits are unchanged.
- R6: With `seg_nosign`=1 and a width below 8, a 0 sign bit is placed above the received bits, so the field is one bit wider. At width 8 the flag has no effect.
- R7: A zero operation (`seg_op`=11) takes no data bits. It clears the register at the start edge, and `wr_done` is high in the next cycle with `busy` still 0.
- R8: Cycles with `sbit_valid`=0 while busy neither consume a bit nor change any register. A field may be split by any number of such gaps.
- R9: `busy` rises after a non-zero start. It falls at the edge that takes the last bit. `wr_done` is high for the one cycle after that edge, and the new value is already readable.
- R10: A `seg_start` received while busy is ignored.
- R11: The repeat register (address 0) is 6 bits wide. A field is aligned to bit 5, field bits below bit 0 are discarded, and bits 7:6 read 0.
- R12: Addresses 17 and above consume the field's bits and pulse `wr_done`, but change no register. Reading them returns 0.
- R13: Register map: 0 repeat, 1 pitch, 2 amplitude, 3+2k B coefficient k, 4+2k F coefficient k (k=0..5), 15 pitch step, 16 amplitude step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_start | input | 1 | Field descriptor valid (accepted when idle) |
| seg_op | input | 2 | 00 load, 01 MSB replace, 10 delta, 11 zero |
| seg_len_m1 | input | 3 | Field width minus one |
| seg_nosign | input | 1 | Field has no sign bit; implicit 0 above it |
| seg_dest | input | 5 | Target register address |
| sbit_valid | input | 1 | Serial data bit valid |
| sbit | input | 1 | Serial data bit, LSB first |
| busy | output | 1 | A field is being received |
| wr_done | output | 1 | One-cycle pulse after a register write |
| rd_sel | input | 5 | Read address for the filter core |
| rd_data | output | 8 | Register contents, zero-extended |

## Verification
The hardest case to reach from the ports is a descriptor that arrives during a stalled field, while the block waits on `sbit_valid`. The field must finish on its own bits, and the register the stray descriptor names must stay unchanged. A directed sequence raises a zero operation in the middle of a gap and then reads both registers. Delta wrap-around with the implicit sign bit also needs a particular history of register values. Directed loads set up those values, and random fields with random gaps and out-of-range addresses cover the remaining combinations against a bench-side model.

// File: rtl/spl_pkg.sv
package spl_pkg;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'b00,
      OP_MSB   = 2'b01,
      OP_DELTA = 2'b10,
      OP_ZERO  = 2'b11
   } spl_op_e;

   // register map (the filter core decodes these addresses)
   localparam int IDX_REPEAT  = 0;
   localparam int IDX_PITCH   = 1;
   localparam int IDX_AMPL    = 2;
   localparam int IDX_COEF0   = 3;
   localparam int NUM_STAGES  = 6;
   localparam int IDX_PSTEP   = IDX_COEF0 + 2 * NUM_STAGES;
   localparam int IDX_ASTEP   = IDX_PSTEP + 1;
   localparam int NUM_ENTRIES = IDX_ASTEP + 1;

endpackage

// File: rtl/spl_deser.sv
// Serial field capture: latches a descriptor, shifts bits in LSB first so the
// field ends up aligned to the top of the capture register, and raises a write
// request on the edge that takes the last bit.
module spl_deser
   import spl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 5,
   parameter int LEN_W  = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                seg_start,
   input  logic [1:0]          seg_op,
   input  logic [LEN_W-1:0]    seg_len_m1,
   input  logic                seg_nosign,
   input  logic [ADDR_W-1:0]   seg_dest,
   input  logic                sbit_valid,
   input  logic                sbit,
   output logic                busy,
   output logic                wr_done,
   output logic                wr_en,
   output spl_op_e             wr_op,
   output logic [ADDR_W-1:0]   wr_dest,
   output logic [DATA_W-1:0]   wr_field,
   output logic [LEN_W:0]      wr_len,
   output logic                wr_nosign
);

   if (DATA_W < 2) begin : g_bad_data_w
      $error("spl_deser: DATA_W must be at least 2");
   end
   if ((1 << LEN_W) != DATA_W) begin : g_bad_len_w
      $error("spl_deser: LEN_W must encode DATA_W widths exactly");
   end

   logic                busy_q;
   logic                done_q;
   logic [LEN_W:0]      left_q;
   logic [DATA_W-1:0]   acc_q;
   spl_op_e             op_q;
   logic [LEN_W:0]      len_q;
   logic                ns_q;
   logic [ADDR_W-1:0]   dst_q;

   logic [DATA_W-1:0]   acc_nx;
   logic                take_bit;
   logic                last_bit;
   logic                zero_now;
   logic                arm;
   spl_op_e             op_in;
   logic [LEN_W:0]      len_in;

   always_comb begin
      op_in    = spl_op_e'(seg_op);
      len_in   = {1'b0, seg_len_m1} + (LEN_W+1)'(1);
      acc_nx   = {sbit, acc_q[DATA_W-1:1]};
      take_bit = busy_q && sbit_valid;
      last_bit = take_bit && (left_q == (LEN_W+1)'(1));
      zero_now = !busy_q && seg_start && (op_in == OP_ZERO);
      arm      = !busy_q && seg_start && (op_in != OP_ZERO);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         left_q <= '0;
         acc_q  <= '0;
         op_q   <= OP_LOAD;
         len_q  <= '0;
         ns_q   <= 1'b0;
         dst_q  <= '0;
      end else begin
         done_q <= last_bit || zero_now;
         if (arm) begin
            busy_q <= 1'b1;
            left_q <= len_in;
            acc_q  <= '0;
            op_q   <= op_in;
            len_q  <= len_in;
            ns_q   <= seg_nosign;
            dst_q  <= seg_dest;
         end else if (take_bit) begin
            acc_q  <= acc_nx;
            left_q <= left_q - (LEN_W+1)'(1);
            if (last_bit) begin
               busy_q <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      busy      = busy_q;
      wr_done   = done_q;
      wr_en     = last_bit || zero_now;
      wr_op     = zero_now ? OP_ZERO  : op_q;
      wr_dest   = zero_now ? seg_dest : dst_q;
      wr_field  = zero_now ? '0       : acc_nx;
      wr_len    = len_q;
      wr_nosign = ns_q;
   end

endmodule

// File: rtl/spl_align.sv
// Turns a top-aligned field into a value and a mask that fit one register
// entry of width CELL_W, inserting the implicit sign bit when requested.
module spl_align #(
   parameter int DATA_W = 8,
   parameter int CELL_W = 8,
   parameter int LEN_W  = 3
) (
   input  logic [DATA_W-1:0] field,
   input  logic [LEN_W:0]    len,
   input  logic              nosign,
   output logic [CELL_W-1:0] val,
   output logic [CELL_W-1:0] mask
);

   if (CELL_W > DATA_W || CELL_W < 1) begin : g_bad_cell_w
      $error("spl_align: CELL_W must lie in 1..DATA_W");
   end

   localparam int DROP = DATA_W - CELL_W;

   logic              widen;
   logic [LEN_W:0]    eff_len;
   logic [DATA_W-1:0] eff_field;
   logic [DATA_W-1:0] top_mask;

   always_comb begin
      widen     = nosign && (len < (LEN_W+1)'(DATA_W));
      eff_len   = len + {{LEN_W{1'b0}}, widen};
      eff_field = widen ? (field >> 1) : field;
      top_mask  = ~({DATA_W{1'b1}} >> eff_len);
   end

   if (DROP == 0) begin : g_full
      always_comb begin
         val  = eff_field;
         mask = top_mask;
      end
   end else begin : g_narrow
      always_comb begin
         val  = CELL_W'(eff_field >> DROP);
         mask = CELL_W'(top_mask  >> DROP);
      end
   end

endmodule

// File: rtl/spl_cell.sv
// One parameter register with the four update operations.
module spl_cell
   import spl_pkg::*;
#(
   parameter int CELL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  spl_op_e           op,
   input  logic [CELL_W-1:0] val,
   input  logic [CELL_W-1:0] mask,
   output logic [CELL_W-1:0] q
);

   logic [CELL_W-1:0] q_r;
   logic [CELL_W-1:0] nxt;

   always_comb begin
      unique case (op)
         OP_LOAD:  nxt = val;
         OP_MSB:   nxt = (val & mask) | (q_r & ~mask);
         OP_DELTA: nxt = q_r + val;
         default:  nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= '0;
      end else if (we) begin
         q_r <= nxt;
      end
   end

   assign q = q_r;

endmodule

// File: rtl/speech_param_loader.sv
module speech_param_loader
   import spl_pkg::*;
#(
   parameter  int NUM_REGS = NUM_ENTRIES,
   parameter  int DATA_W   = 8,
   parameter  int REP_W    = 6,
   parameter  int REP_IDX  = IDX_REPEAT,
   localparam int ADDR_W   = $clog2(NUM_REGS),
   localparam int LEN_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_start,
   input  logic [1:0]        seg_op,
   input  logic [LEN_W-1:0]  seg_len_m1,
   input  logic              seg_nosign,
   input  logic [ADDR_W-1:0] seg_dest,
   input  logic              sbit_valid,
   input  logic              sbit,
   output logic              busy,
   output logic              wr_done,
   input  logic [ADDR_W-1:0] rd_sel,
   output logic [DATA_W-1:0] rd_data
);

   if (NUM_REGS < 2) begin : g_bad_num
      $error("speech_param_loader: NUM_REGS must be at least 2");
   end
   if (REP_W < 1 || REP_W > DATA_W) begin : g_bad_rep_w
      $error("speech_param_loader: REP_W must lie in 1..DATA_W");
   end
   if (REP_IDX < 0 || REP_IDX >= NUM_REGS) begin : g_bad_rep_idx
      $error("speech_param_loader: REP_IDX out of range");
   end

   logic                wr_en;
   spl_op_e             wr_op;
   logic [ADDR_W-1:0]   wr_dest;
   logic [DATA_W-1:0]   wr_field;
   logic [LEN_W:0]      wr_len;
   logic                wr_nosign;
   logic [DATA_W-1:0]   q_all [NUM_REGS];

   spl_deser #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) u_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .seg_start  (seg_start),
      .seg_op     (seg_op),
      .seg_len_m1 (seg_len_m1),
      .seg_nosign (seg_nosign),
      .seg_dest   (seg_dest),
      .sbit_valid (sbit_valid),
      .sbit       (sbit),
      .busy       (busy),
      .wr_done    (wr_done),
      .wr_en      (wr_en),
      .wr_op      (wr_op),
      .wr_dest    (wr_dest),
      .wr_field   (wr_field),
      .wr_len     (wr_len),
      .wr_nosign  (wr_nosign)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
      localparam int CW = (i == REP_IDX) ? REP_W : DATA_W;

      logic [CW-1:0] a_val;
      logic [CW-1:0] a_mask;
      logic [CW-1:0] c_q;
      logic          c_we;

      assign c_we = wr_en && (wr_dest == ADDR_W'(i));

      spl_align #(
         .DATA_W (DATA_W),
         .CELL_W (CW),
         .LEN_W  (LEN_W)
      ) u_align (
         .field  (wr_field),
         .len    (wr_len),
         .nosign (wr_nosign),
         .val    (a_val),
         .mask   (a_mask)
      );

      spl_cell #(
         .CELL_W (CW)
      ) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (c_we),
         .op    (wr_op),
         .val   (a_val),
         .mask  (a_mask),
         .q     (c_q)
      );

      if (CW == DATA_W) begin : g_wide
         assign q_all[i] = c_q;
      end else begin : g_ext
         assign q_all[i] = {{(DATA_W-CW){1'b0}}, c_q};
      end
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (rd_sel == ADDR_W'(k)) begin
            rd_data = q_all[k];
         end
      end
   end

endmodule

// File: rtl/speech_param_loader_chk.sv
module speech_param_loader_chk #(
   parameter int NUM_REGS = 17,
   parameter int DATA_W   = 8,
   parameter int REP_W    = 6,
   parameter int REP_IDX  = 0,
   parameter int ADDR_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              seg_start,
   input logic [1:0]        seg_op,
   input logic [ADDR_W-1:0] seg_dest,
   input logic              sbit_valid,
   input logic              busy,
   input logic              wr_done,
   input logic [ADDR_W-1:0] rd_sel,
   input logic [DATA_W-1:0] rd_data
);

   // R1: state is idle in the cycle after reset is held
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |=> (!busy && !wr_done));

   // R7: zero operation clears and signals without going busy
   p_zero_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && seg_start && seg_op == 2'b11 && seg_dest == rd_sel
       && int'(seg_dest) < NUM_REGS)
      |=> (wr_done && !busy && (!$stable(rd_sel) || rd_data == '0)));

   // R8: a gap keeps the field open
   p_gap_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sbit_valid) |=> busy);

   // R8: idle cycles leave every register alone
   p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !seg_start) |=> (!$stable(rd_sel) || $stable(rd_data)));

   // R10: a start during a gap writes nothing
   p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !sbit_valid && seg_start) |=> (busy && (!$stable(rd_sel) || $stable(rd_data))));

   // R9: data-carrying start opens a field
   p_start_arms_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && seg_start && seg_op != 2'b11) |=> (busy && !wr_done));

   // R9: end of a field is always signalled
   p_done_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> wr_done);

   // R12: unmapped addresses read zero
   p_oob_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rd_sel) >= NUM_REGS) |-> (rd_data == '0));

   if (REP_W < DATA_W) begin : g_rep_chk
      // R11: upper bits of the narrow repeat entry stay clear
      p_rep_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(rd_sel) == REP_IDX) |-> (rd_data[DATA_W-1:REP_W] == '0));
   end

endmodule

bind speech_param_loader speech_param_loader_chk #(
   .NUM_REGS (NUM_REGS),
   .DATA_W   (DATA_W),
   .REP_W    (REP_W),
   .REP_IDX  (REP_IDX),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .seg_start  (seg_start),
   .seg_op     (seg_op),
   .seg_dest   (seg_dest),
   .sbit_valid (sbit_valid),
   .busy       (busy),
   .wr_done    (wr_done),
   .rd_sel     (rd_sel),
   .rd_data    (rd_data)
);

// File: tb/sim_speech_param_loader.sv
module sim_speech_param_loader;

   localparam int CLK_PERIOD = 10;
   localparam int NREG       = 17;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       seg_start = 1'b0;
   logic [1:0] seg_op = 2'b00;
   logic [2:0] seg_len_m1 = 3'd0;
   logic       seg_nosign = 1'b0;
   logic [4:0] seg_dest = 5'd0;
   logic       sbit_valid = 1'b0;
   logic       sbit = 1'b0;
   logic       busy;
   logic       wr_done;
   logic [4:0] rd_sel = 5'd0;
   logic [7:0] rd_data;

   int n_chk  = 0;
   int n_fail = 0;
   bit ended  = 0;
   int mdl [NREG];

   always #(CLK_PERIOD/2) clk = ~clk;

   speech_param_loader u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .seg_start  (seg_start),
      .seg_op     (seg_op),
      .seg_len_m1 (seg_len_m1),
      .seg_nosign (seg_nosign),
      .seg_dest   (seg_dest),
      .sbit_valid (sbit_valid),
      .sbit       (sbit),
      .busy       (busy),
      .wr_done    (wr_done),
      .rd_sel     (rd_sel),
      .rd_data    (rd_data)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   // expected register update, from the requirement text
   function automatic int model_next(input int old, input int op, input int w,
                                     input bit ns, input int v, input int rw);
      int ew, vm, jv, mk, full, r;
      vm   = v & ((1 << w) - 1);
      ew   = (ns && w < 8) ? w + 1 : w;
      full = (1 << rw) - 1;
      if (rw >= ew) begin
         jv = vm << (rw - ew);
         mk = ((1 << ew) - 1) << (rw - ew);
      end else begin
         jv = vm >> (ew - rw);
         mk = full;
      end
      case (op)
         0:       r = jv;
         1:       r = (jv & mk) | (old & ~mk);
         2:       r = old + jv;
         default: r = 0;
      endcase
      return r & full;
   endfunction

   function automatic int reg_w(input int a);
      return (a == 0) ? 6 : 8;
   endfunction

   task automatic rd(input int a, output int d);
      rd_sel = a[4:0];
      #1;
      d = int'(rd_data);
   endtask

   task automatic chk_reg(input string tag, input int a);
      int d;
      rd(a, d);
      chk(tag, $sformatf("reg %0d", a), d, (a < NREG) ? mdl[a] : 0);
   endtask

   task automatic sweep(input string tag);
      for (int k = 0; k < NREG; k++) chk_reg(tag, k);
   endtask

   // one field: descriptor cycle, then LSB-first bits with optional gaps
   task automatic send(input int op, input int w, input bit ns, input int dest,
                       input int v, input bit gaps);
      @(negedge clk);
      seg_start  = 1'b1;
      seg_op     = op[1:0];
      seg_len_m1 = 3'(w - 1);
      seg_nosign = ns;
      seg_dest   = dest[4:0];
      @(negedge clk);
      seg_start = 1'b0;
      if (op == 3) begin
         chk("R7", "done after zero", {30'd0, wr_done, busy}, 32'd2);
      end else begin
         for (int i = 0; i < w; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
               sbit_valid = 1'b0;
               repeat (1 + $urandom % 3) @(negedge clk);
            end
            sbit_valid = 1'b1;
            sbit       = v[i];
            @(negedge clk);
         end
         sbit_valid = 1'b0;
         chk("R9", "done/busy after last bit", {30'd0, wr_done, busy}, 32'd2);
      end
      if (dest < NREG) mdl[dest] = model_next(mdl[dest], op, w, ns, v, reg_w(dest));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      int d;
      void'($urandom(32'd5821));
      for (int k = 0; k < NREG; k++) mdl[k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy/done after reset", {30'd0, wr_done, busy}, 32'd0);
      sweep("R1");

      // R2: 8-bit load, LSB first
      send(0, 8, 0, 1, 8'hA5, 0);
      chk_reg("R2", 1);
      rd(1, d); chk("R2", "pitch literal", d, 32'hA5);
      // R3: narrow load, lower bits cleared
      send(0, 8, 0, 3, 8'hFF, 0);
      send(0, 3, 0, 3, 3'b101, 0);
      rd(3, d); chk("R3", "narrow load", d, 32'hA0);
      // R4: MSB replace keeps low bits
      send(0, 8, 0, 4, 8'h5B, 0);
      send(1, 4, 0, 4, 4'h3, 0);
      rd(4, d); chk("R4", "msb replace", d, 32'h3B);
      // R5: delta of -1, and a wrapping delta
      send(2, 4, 0, 4, 4'hF, 1);
      rd(4, d); chk("R5", "negative delta", d, 32'h2B);
      send(0, 8, 0, 5, 8'hF3, 0);
      send(2, 4, 0, 5, 4'h2, 0);
      rd(5, d); chk("R5", "wrapping delta", d, 32'h13);
      // R6: implicit sign bit on load and delta; ignored at width 8
      send(0, 3, 1, 6, 3'b111, 0);
      rd(6, d); chk("R6", "unsigned load", d, 32'h70);
      send(2, 2, 1, 5, 2'b11, 0);
      rd(5, d); chk("R6", "unsigned delta", d, 32'h73);
      send(0, 8, 1, 7, 8'hC4, 0);
      rd(7, d); chk("R6", "flag at width 8", d, 32'hC4);
      // R11: repeat register width
      send(0, 4, 0, 0, 4'hA, 0);
      rd(0, d); chk("R11", "repeat narrow", d, 32'h28);
      send(0, 8, 0, 0, 8'hFF, 0);
      rd(0, d); chk("R11", "repeat wide", d, 32'h3F);
      // R7: zero operation
      send(3, 1, 0, 1, 0, 0);
      rd(1, d); chk("R7", "cleared", d, 32'h0);
      // R12: unmapped address
      send(0, 5, 0, 20, 5'h1F, 1);
      rd(20, d); chk("R12", "unmapped read", d, 32'h0);
      sweep("R12");
      // R13: map ends: amplitude step at 16
      send(0, 8, 0, 16, 8'h3C, 0);
      rd(16, d); chk("R13", "amplitude step", d, 32'h3C);

      // R10 and R8: stray zero start during a gap
      send(0, 8, 0, 9, 8'h77, 0);
      @(negedge clk);
      seg_start = 1'b1; seg_op = 2'b00; seg_len_m1 = 3'd3; seg_nosign = 1'b0; seg_dest = 5'd10;
      @(negedge clk);
      seg_start = 1'b0;
      sbit_valid = 1'b1; sbit = 1'b1;
      @(negedge clk);
      sbit_valid = 1'b0;
      seg_start = 1'b1; seg_op = 2'b11; seg_dest = 5'd9;
      @(negedge clk);
      seg_start = 1'b0;
      @(negedge clk);
      chk("R8", "busy through gap", {31'd0, busy}, 32'd1);
      for (int i = 1; i < 4; i++) begin
         sbit_valid = 1'b1;
         sbit = (i == 3);
         @(negedge clk);
      end
      sbit_valid = 1'b0;
      chk("R9", "done after split field", {30'd0, wr_done, busy}, 32'd2);
      mdl[10] = 8'h90;
      rd(9, d);  chk("R10", "stray start ignored", d, 32'h77);
      rd(10, d); chk("R10", "field completed", d, 32'h90);

      // random fields with gaps, including unmapped addresses
      for (int n = 0; n < 300; n++) begin
         int op, w, a, v;
         bit ns;
         op = $urandom % 4;
         w  = 1 + $urandom % 8;
         ns = 1'($urandom % 2);
         a  = $urandom % 19;
         v  = $urandom % 256;
         send(op, w, ns, a, v, 1);
         chk_reg((op == 2) ? "R5" : (op == 1) ? "R4" : "R3", a);
      end
      sweep("R8");
      finish_run();
   end

endmodule